// File: doc/BRIEF.md
# Detection Report Packetizer

This block gathers the report records that a synchronization-signal detector raises during a search and packs them into fixed-length packets for a DMA stream toward a processor. A record has five numeric words: sector identifier, frequency offset, timing offset, correlation strength and signal threshold. Records arrive as single-cycle strobes with no back-pressure toward the detector.

Every packet is exactly 244 words long. The first word is the number of valid records (0 to 48). The records follow in arrival order, five words each, and zero words fill the rest. A packet is closed either when its 48th record lands or when the search-done strobe arrives. A done strobe with no records still yields a full packet whose count is zero. The output is a valid/ready/last stream, and the last marker sits on word 244.

Two record banks alternate between filling and emitting, so records keep being collected while a closed packet waits for or undergoes transmission. When both banks hold closed packets, further records and done strobes are discarded until the older packet has gone out.

Top module: `det_report_packer`

## Requirements
- R1: After reset, and with no record or done strobe, `m_tvalid` stays low.
- R2: Every packet is exactly 244 accepted words, and `m_tlast` is high on the 244th word and on no other.
- R3: Word 1 of a packet holds the number of valid records, zero-extended in the low bits, with a value from 0 to 48.
- R4: Words 2 to 1+5n carry the n records in arrival order, each as sector, frequency offset, timing offset, correlation strength, threshold.
- R5: All words after the last record up to word 244 are zero.
- R6: The record that brings a bank to 48 closes that packet without any done strobe, and the following record starts a new packet.
- R7: A done strobe closes the collecting packet. With no records collected it yields a count-zero packet. A record in the same cycle as the done strobe belongs to the packet being closed.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R9: Records that arrive while an earlier packet waits or is being sent are collected into the other bank and emitted as the next packet, with nothing lost or reordered.
- R10: While both banks hold closed packets, arriving records and done strobes are discarded and appear in no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | Record strobe, one cycle per record |
| rpt_sector | input | 32 | Sector identifier of the record |
| rpt_freq | input | 32 | Frequency offset of the record |
| rpt_timing | input | 32 | Timing offset of the record |
| rpt_corr | input | 32 | Correlation strength of the record |
| rpt_thresh | input | 32 | Signal threshold of the record |
| search_done | input | 1 | Closes the collecting packet |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream word accepted by the sink |
| m_tdata | output | 32 | Stream word |
| m_tlast | output | 1 | Final word of a packet |

## Verification
The bench targets the count-zero flush, which a design that skipped empty packets would simply never send. It also covers the record that arrives together with the done strobe, which a wrong design would push into the next packet, and the 48th record, where an off-by-one would close the packet at 47 or 49 records. Under a stalled sink it fills the second bank, then overfills both banks. A design that overwrote a waiting bank would send corrupted records, and one that let dropped records leak would show them in a later packet. Random ready patterns look for words repeated or skipped across stalls and for a last marker off word 244.

// File: rtl/detpkt_pkg.sv
package detpkt_pkg;

    localparam int WORD_W     = 32;
    localparam int MAX_REC    = 48;
    localparam int REC_FIELDS = 5;
    localparam int PKT_WORDS  = 244;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t sector;
        word_t freq_off;
        word_t time_off;
        word_t corr;
        word_t thresh;
    } report_t;

    // Field order within a record on the stream.
    function automatic word_t pick_field(report_t r, logic [2:0] idx);
        word_t v;
        case (idx)
            3'd0:    v = r.sector;
            3'd1:    v = r.freq_off;
            3'd2:    v = r.time_off;
            3'd3:    v = r.corr;
            3'd4:    v = r.thresh;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/detpkt_bank.sv
module detpkt_bank
    import detpkt_pkg::*;
#(
    parameter int MAX_RECS = MAX_REC,
    localparam int IDX_W = $clog2(MAX_RECS),
    localparam int CNT_W = $clog2(MAX_RECS + 1)
) (
    input  logic             clk,
    input  logic             we,
    input  logic             wbank,
    input  logic [IDX_W-1:0] widx,
    input  report_t          wrec,
    input  logic             rbank,
    input  logic [CNT_W-1:0] ridx,
    output report_t          rrec
);

    report_t rd_b [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        report_t mem_q [MAX_RECS];

        always_ff @(posedge clk) begin
            if (we && (wbank == b[0])) begin
                mem_q[widx] <= wrec;
            end
        end

        assign rd_b[b] = (ridx < CNT_W'(MAX_RECS)) ? mem_q[ridx[IDX_W-1:0]] : '0;
    end

    assign rrec = rd_b[rbank];

endmodule

// File: rtl/detpkt_fill.sv
module detpkt_fill
    import detpkt_pkg::*;
#(
    parameter int MAX_RECS = MAX_REC,
    localparam int IDX_W = $clog2(MAX_RECS),
    localparam int CNT_W = $clog2(MAX_RECS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rec_valid,
    input  logic                  flush_req,
    input  logic                  release_i,
    input  logic                  release_bank,
    output logic [1:0]            sealed_o,
    output logic [1:0][CNT_W-1:0] cnt_o,
    output logic                  we_o,
    output logic                  wbank_o,
    output logic [IDX_W-1:0]      widx_o
);

    logic [1:0]            sealed_q;
    logic [1:0][CNT_W-1:0] cnt_q;
    logic                  wr_q;
    logic                  open_bank;
    logic                  accept;
    logic                  close;

    assign open_bank = !sealed_q[wr_q];
    assign accept    = rec_valid && open_bank;
    assign close     = open_bank &&
                       (flush_req || (accept && (cnt_q[wr_q] == CNT_W'(MAX_RECS - 1))));

    always_ff @(posedge clk) begin
        if (rst) begin
            sealed_q <= '0;
            cnt_q    <= '0;
            wr_q     <= 1'b0;
        end else begin
            if (accept) begin
                cnt_q[wr_q] <= cnt_q[wr_q] + 1'b1;
            end
            if (close) begin
                sealed_q[wr_q] <= 1'b1;
                wr_q           <= ~wr_q;
            end
            // The released bank is sealed, so it never equals an accepting bank.
            if (release_i) begin
                sealed_q[release_bank] <= 1'b0;
                cnt_q[release_bank]    <= '0;
            end
        end
    end

    assign sealed_o = sealed_q;
    assign cnt_o    = cnt_q;
    assign we_o     = accept;
    assign wbank_o  = wr_q;
    assign widx_o   = cnt_q[wr_q][IDX_W-1:0];

endmodule

// File: rtl/detpkt_emit.sv
module detpkt_emit
    import detpkt_pkg::*;
#(
    parameter int MAX_RECS = MAX_REC,
    parameter int PKT_LEN  = PKT_WORDS,
    localparam int CNT_W = $clog2(MAX_RECS + 1),
    localparam int POS_W = $clog2(PKT_LEN)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            sealed,
    input  logic [1:0][CNT_W-1:0] cnt_all,
    input  report_t               rrec,
    input  logic                  tready,
    output logic                  rd_bank,
    output logic [CNT_W-1:0]      ridx,
    output logic                  tvalid,
    output word_t                 tdata,
    output logic                  tlast,
    output logic                  release_o
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);
    localparam logic [2:0]       FLD_LAST = 3'(REC_FIELDS - 1);

    logic             busy_q;
    logic             rb_q;
    logic [POS_W-1:0] pos_q;
    logic [CNT_W-1:0] rec_q;
    logic [2:0]       fld_q;
    logic [CNT_W-1:0] pkt_cnt;
    logic             at_end;

    assign pkt_cnt = cnt_all[rb_q];
    assign at_end  = (pos_q == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rb_q   <= 1'b0;
            pos_q  <= '0;
            rec_q  <= '0;
            fld_q  <= '0;
        end else if (!busy_q) begin
            if (sealed[rb_q]) begin
                busy_q <= 1'b1;
                pos_q  <= '0;
                rec_q  <= '0;
                fld_q  <= '0;
            end
        end else if (tready) begin
            if (at_end) begin
                busy_q <= 1'b0;
                rb_q   <= ~rb_q;
            end else begin
                pos_q <= pos_q + 1'b1;
                if (pos_q != '0) begin
                    if (fld_q == FLD_LAST) begin
                        fld_q <= '0;
                        if (rec_q < CNT_W'(MAX_RECS)) begin
                            rec_q <= rec_q + 1'b1;
                        end
                    end else begin
                        fld_q <= fld_q + 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        if (pos_q == '0) begin
            tdata = word_t'(pkt_cnt);
        end else if (rec_q < pkt_cnt) begin
            tdata = pick_field(rrec, fld_q);
        end else begin
            tdata = '0;
        end
    end

    assign rd_bank   = rb_q;
    assign ridx      = rec_q;
    assign tvalid    = busy_q;
    assign tlast     = busy_q && at_end;
    assign release_o = busy_q && tready && at_end;

endmodule

// File: rtl/det_report_packer.sv
module det_report_packer
    import detpkt_pkg::*;
#(
    parameter int MAX_RECS = MAX_REC,
    parameter int PKT_LEN  = PKT_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rpt_valid,
    input  logic [WORD_W-1:0] rpt_sector,
    input  logic [WORD_W-1:0] rpt_freq,
    input  logic [WORD_W-1:0] rpt_timing,
    input  logic [WORD_W-1:0] rpt_corr,
    input  logic [WORD_W-1:0] rpt_thresh,
    input  logic              search_done,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [WORD_W-1:0] m_tdata,
    output logic              m_tlast
);

    localparam int IDX_W = $clog2(MAX_RECS);
    localparam int CNT_W = $clog2(MAX_RECS + 1);

    report_t               wrec;
    report_t               rrec;
    logic [1:0]            sealed;
    logic [1:0][CNT_W-1:0] cnt_all;
    logic                  we;
    logic                  wbank;
    logic [IDX_W-1:0]      widx;
    logic                  rd_bank;
    logic [CNT_W-1:0]      ridx;
    logic                  rel;

    assign wrec = '{sector:   rpt_sector,
                    freq_off: rpt_freq,
                    time_off: rpt_timing,
                    corr:     rpt_corr,
                    thresh:   rpt_thresh};

    detpkt_fill #(.MAX_RECS(MAX_RECS)) u_fill (
        .clk          (clk),
        .rst          (rst),
        .rec_valid    (rpt_valid),
        .flush_req    (search_done),
        .release_i    (rel),
        .release_bank (rd_bank),
        .sealed_o     (sealed),
        .cnt_o        (cnt_all),
        .we_o         (we),
        .wbank_o      (wbank),
        .widx_o       (widx)
    );

    detpkt_bank #(.MAX_RECS(MAX_RECS)) u_bank (
        .clk   (clk),
        .we    (we),
        .wbank (wbank),
        .widx  (widx),
        .wrec  (wrec),
        .rbank (rd_bank),
        .ridx  (ridx),
        .rrec  (rrec)
    );

    detpkt_emit #(.MAX_RECS(MAX_RECS), .PKT_LEN(PKT_LEN)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .sealed    (sealed),
        .cnt_all   (cnt_all),
        .rrec      (rrec),
        .tready    (m_tready),
        .rd_bank   (rd_bank),
        .ridx      (ridx),
        .tvalid    (m_tvalid),
        .tdata     (m_tdata),
        .tlast     (m_tlast),
        .release_o (rel)
    );

endmodule

// File: rtl/det_report_packer_chk.sv
module det_report_packer_chk
    import detpkt_pkg::*;
#(
    parameter int MAX_RECS = MAX_REC,
    parameter int PKT_LEN  = PKT_WORDS,
    localparam int POS_W = $clog2(PKT_LEN)
) (
    input logic              clk,
    input logic              rst,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [WORD_W-1:0] m_tdata,
    input logic              m_tlast
);

    logic [POS_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (m_tvalid && m_tready) begin
            beat_q <= (beat_q == POS_W'(PKT_LEN - 1)) ? '0 : beat_q + 1'b1;
        end
    end

    a_r8_hold_valid: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> m_tvalid);

    a_r8_hold_data: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> ($stable(m_tdata) && $stable(m_tlast)));

    a_r2_last_position: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> (m_tlast == (beat_q == POS_W'(PKT_LEN - 1))));

    a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && beat_q == '0) |-> (m_tdata <= WORD_W'(MAX_RECS)));

    a_r5_tail_zero: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && (int'(beat_q) > REC_FIELDS * MAX_RECS)) |-> (m_tdata == '0));

endmodule

bind det_report_packer det_report_packer_chk #(
    .MAX_RECS (MAX_RECS),
    .PKT_LEN  (PKT_LEN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast)
);

// File: tb/det_report_packer_bench.sv
`timescale 1ns/100ps
module det_report_packer_bench;
    import detpkt_pkg::*;

    localparam int NREC = MAX_REC;
    localparam int PLEN = PKT_WORDS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rpt_valid = 1'b0;
    logic [31:0] rpt_sector = '0, rpt_freq = '0, rpt_timing = '0, rpt_corr = '0, rpt_thresh = '0;
    logic        search_done = 1'b0;
    logic        m_tvalid;
    logic        m_tready = 1'b0;
    logic [31:0] m_tdata;
    logic        m_tlast;

    int checks = 0;
    int errors = 0;
    int ready_mode = 1;   // 0 low, 1 high, 2 random
    int stall_err = 0;
    bit finished = 0;
    string cur_tag = "R1";

    logic [31:0] exp_q [$];
    logic [31:0] cur [$];

    always #2.5 clk = ~clk;

    det_report_packer u_det_report_packer (
        .clk(clk), .rst(rst), .rpt_valid(rpt_valid),
        .rpt_sector(rpt_sector), .rpt_freq(rpt_freq), .rpt_timing(rpt_timing),
        .rpt_corr(rpt_corr), .rpt_thresh(rpt_thresh), .search_done(search_done),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
    );

    // Expected packet: count, records in order, zero padding to PLEN words.
    task automatic flush_model();
        int n = cur.size() / REC_FIELDS;
        exp_q.push_back(32'(n));
        foreach (cur[i]) exp_q.push_back(cur[i]);
        for (int k = 1 + cur.size(); k < PLEN; k++) exp_q.push_back(32'd0);
        cur.delete();
    endtask

    task automatic drive(input bit v, input bit d, input bit model);
        rpt_valid   = v;
        search_done = d;
        if (v) begin
            rpt_sector = $urandom; rpt_freq = $urandom; rpt_timing = $urandom;
            rpt_corr = $urandom;   rpt_thresh = $urandom;
        end
        if (model) begin
            if (v) begin
                cur.push_back(rpt_sector); cur.push_back(rpt_freq);
                cur.push_back(rpt_timing); cur.push_back(rpt_corr);
                cur.push_back(rpt_thresh);
            end
            if ((v && cur.size() == REC_FIELDS * NREC) || d) flush_model();
        end
        @(negedge clk);
        rpt_valid   = 1'b0;
        search_done = 1'b0;
    endtask

    task automatic wait_drained();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    // Stream monitor: set ready after the falling edge, sample 1 ns later.
    initial begin : monitor
        int  beat = 0;
        bit  bad = 0;
        bit  prev_stall = 0;
        logic [31:0] prev_data = '0;
        logic [31:0] e;
        forever begin
            @(negedge clk);
            case (ready_mode)
                0:       m_tready = 1'b0;
                1:       m_tready = 1'b1;
                default: m_tready = ($urandom_range(0, 3) != 0);
            endcase
            #1;
            if (prev_stall && !(m_tvalid && m_tdata == prev_data)) stall_err++;
            prev_stall = m_tvalid && !m_tready;
            prev_data  = m_tdata;
            if (m_tvalid && m_tready) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL %s unexpected word: actual %h expected none", cur_tag, m_tdata);
                end else begin
                    e = exp_q.pop_front();
                    if (m_tdata !== e) begin
                        bad = 1;
                        $display("FAIL %s %s word %0d: actual %h expected %h", cur_tag,
                                 (beat == 0) ? "R3" : ((beat <= REC_FIELDS * NREC) ? "R4" : "R5"),
                                 beat, m_tdata, e);
                    end
                    if (m_tlast !== (beat == PLEN - 1)) begin
                        bad = 1;
                        $display("FAIL %s R2 last at word %0d: actual %0b expected %0b",
                                 cur_tag, beat, m_tlast, (beat == PLEN - 1));
                    end
                    if (beat == PLEN - 1) begin
                        checks++;
                        if (bad) errors++;
                        bad = 0;
                        beat = 0;
                    end else begin
                        beat++;
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        bit seen;
        void'($urandom(32'h1357_2468));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: idle after reset
        seen = 0;
        repeat (20) begin @(negedge clk); #1; if (m_tvalid) seen = 1; end
        checks++;
        if (seen) begin errors++; $display("FAIL R1 idle valid: actual 1 expected 0"); end

        // R7: empty flush gives a count-zero packet
        cur_tag = "R7 empty";
        drive(0, 1, 1); wait_drained();

        // R7: partial packet closed by done
        cur_tag = "R7 partial";
        for (int i = 0; i < 3; i++) drive(1, 0, 1);
        drive(0, 1, 1); wait_drained();

        // R7: record together with done belongs to the closing packet
        cur_tag = "R7 same-cycle";
        drive(1, 0, 1); drive(1, 1, 1); wait_drained();

        // R6: 48th record closes the packet, the next starts a new one
        cur_tag = "R6 full";
        for (int i = 0; i < NREC; i++) drive(1, 0, 1);
        drive(1, 0, 1); drive(0, 1, 1); wait_drained();

        // R9: second bank fills while the first is stalled
        cur_tag = "R9 second bank";
        ready_mode = 0;
        for (int i = 0; i < NREC; i++) drive(1, 0, 1);
        for (int i = 0; i < 5; i++) drive(1, 0, 1);
        drive(0, 1, 1);
        repeat (10) @(negedge clk);
        ready_mode = 1;
        wait_drained();

        // R10: both banks closed, extra records and done are discarded
        cur_tag = "R10 overflow";
        ready_mode = 0;
        for (int i = 0; i < 2 * NREC; i++) drive(1, 0, 1);
        for (int i = 0; i < 3; i++) drive(1, 0, 0);
        drive(0, 1, 0);
        repeat (10) @(negedge clk);
        ready_mode = 1;
        wait_drained();
        for (int i = 0; i < 2; i++) drive(1, 0, 1);
        drive(0, 1, 1); wait_drained();

        // R8: random sizes under random back-pressure
        cur_tag = "R8 random";
        ready_mode = 2;
        for (int p = 0; p < 20; p++) begin
            int n = $urandom_range(0, NREC);
            for (int i = 0; i < n; i++) begin
                bit tail = (i == n - 1) && (n < NREC) && ($urandom_range(0, 1) == 1);
                drive(1, tail, 1);
                if (tail) n = -1;
                repeat ($urandom_range(0, 3)) @(negedge clk);
            end
            if (n >= 0 && n < NREC) drive(0, 1, 1);
            wait_drained();
        end
        ready_mode = 1;
        repeat (20) @(negedge clk);

        checks++;
        if (stall_err != 0) begin
            errors++;
            $display("FAIL R8 stall hold: actual %0d violations expected 0", stall_err);
        end
        checks++;
        if (exp_q.size() != 0 || m_tvalid) begin
            errors++;
            $display("FAIL R2 leftover words: actual %0d expected 0", exp_q.size());
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule